// File: doc/BRIEF.md
# Orbit-Aligned Channel Synchronization FIFO

This block re-times one trigger-tower channel from the clock of its own transmitter into a receive clock that every channel shares. Each 9-bit word carries an 8-bit transverse-energy value and a fine-grain bit, and one word arrives per bunch crossing. Writing starts on a transmit-side orbit marker. A programmable cycle count can move that marker later to trim the alignment of the channel. Reading starts on a receive-side orbit marker that reaches all channels on the same receive edge. Channels that are filled at different times therefore present the same crossing on the same receive cycle.

Once per orbit, during the main beam gap, a flush pulse empties the storage. Any slip that has built up is discarded at that point. The read side then waits for the next receive marker. Write and read pointers cross between the two clock domains in Gray code through two-flop synchronizers. Storage is a 128-word dual-clock memory. A sticky error bit records overflow and underflow. A channel-enable input silences a channel that is not in use.

Top module: `orbit_sync_fifo`

## Requirements
- R1: While either reset is low, and right after reset, `rd_valid` is 0, `rd_data` is 0 and `sync_err` is 0.
- R2: On a `wr_orbit` pulse, the effective write marker occurs `cfg_delay` write cycles later (in the same cycle when the delay is 0). The first word stored after a flush is the word presented in that cycle.
- R3: Stored words come out on `rd_data` in the order they were written, one per `rd_valid` cycle, with all 9 bits unchanged. A run with a backlog raises no error.
- R4: `rd_valid` stays 0 after a flush until a `rd_orbit` pulse arrives, even when words are stored. It is 0 from the second receive cycle after `flush`.
- R5: `flush` discards every stored word. After it, the first word read following the next `rd_orbit` is the first word written at the next effective write marker.
- R6: The storage holds exactly 128 words. A write arriving while 128 words are held is dropped, the held words stay intact and in order, and `sync_err` is set.
- R7: When reading has been released by `rd_orbit` and the storage is empty, `sync_err` is set and `rd_valid` stays 0.
- R8: `sync_err` stays 1 until an `err_clr` pulse, and a flush does not clear it. If a new error event coincides with `err_clr`, the bit stays set.
- R9: While `chan_en` is 0, `rd_valid` is 0, `rd_data` is 0 and `sync_err` is never set, even if reading was released or data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Transmit-side clock, one word per cycle |
| wr_rst_n | input | 1 | Active-low synchronous reset, write domain |
| wr_orbit | input | 1 | Transmit orbit marker, one-cycle pulse |
| wr_data | input | 9 | Tower word: energy in bits 7:0, fine-grain flag in bit 8 |
| cfg_delay | input | 12 | Write-cycle delay applied to the orbit marker |
| rd_clk | input | 1 | Common receive clock |
| rd_rst_n | input | 1 | Active-low synchronous reset, read domain |
| rd_orbit | input | 1 | Shared receive orbit marker that releases reading |
| flush | input | 1 | Per-orbit clear pulse, read domain |
| chan_en | input | 1 | Channel enable, read domain |
| err_clr | input | 1 | Clears the sticky error bit, read domain |
| rd_data | output | 9 | Realigned word, 0 when not valid |
| rd_valid | output | 1 | A word is on `rd_data` this cycle |
| sync_err | output | 1 | Sticky overflow or underflow flag |

## Verification
The bench builds the block with its default parameters: 9-bit words, 128-word storage and a 12-bit delay. The depth is small enough that a 150-word burst with no reads fills the storage. The bench then reads all 128 held words and the first word written after space frees up. The 12-bit delay covers the delays tried, from 0 and 1 up to 200 cycles, each of which moves the first stored word by that many crossings. Both clocks run at the same rate with a fixed phase offset, so underflow appears only when reading is released with nothing stored.

// File: rtl/osf_pkg.sv
// Shared constants and types for the orbit-aligned synchronization FIFO.
package osf_pkg;
    localparam int unsigned OSF_DATA_W = 9;
    localparam int unsigned OSF_DEPTH  = 128;
    localparam int unsigned OSF_DLY_W  = 12;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RUN  = 1'b1
    } rd_state_e;
endpackage

// File: rtl/osf_sync2.sv
// Two-flop synchronizer for a vector whose bits change one at a time
// (Gray pointers or toggles). Assumes the source is registered.
module osf_sync2 #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/osf_orbit_delay.sv
// Produces the effective write marker DLY cycles after an orbit pulse.
// DLY = 0 gives the marker in the same cycle as the pulse. A new pulse
// restarts the count.
module osf_orbit_delay #(
    parameter int unsigned DLY_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             orbit_in,
    input  logic [DLY_W-1:0] delay,
    output logic             mark_out
);
    logic [DLY_W-1:0] cnt;
    logic             busy;

    // Marker fires at once for zero delay, else when the count reaches one.
    always_comb begin
        mark_out = (orbit_in && (delay == '0)) || (busy && (cnt == DLY_W'(1)));
    end

    // Load the delay on a pulse and count down while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
        end else if (orbit_in) begin
            cnt  <= delay;
            busy <= (delay != '0);
        end else if (busy) begin
            cnt <= cnt - DLY_W'(1);
            if (cnt == DLY_W'(1)) begin
                busy <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/osf_dpram.sv
// Dual-clock storage: registered write port on the write clock and a
// combinational read port whose result the read side registers.
module osf_dpram #(
    parameter int unsigned DW = 9,
    parameter int unsigned AW = 7
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store one word per enabled write cycle.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Present the addressed word to the read register.
    always_comb begin
        rdata = mem[raddr];
    end
endmodule

// File: rtl/osf_wr_ctrl.sv
// Write-side control: arming by the effective marker, Gray write pointer,
// full detection against the synchronized read pointer, overflow toggle,
// and the flush request brought in from the read domain.
// Assumes AW >= 2 and a registered toggle source for the flush request.
module osf_wr_ctrl #(
    parameter int unsigned AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mark,
    input  logic [AW:0]   rd_gray_x,
    input  logic          flush_tgl_x,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW:0]   wr_gray,
    output logic          ovf_tgl,
    output logic          flush_evt
);
    logic [AW:0] rd_gray_s;
    logic        flush_s;
    logic        flush_prev;
    logic        active;
    logic [AW:0] wr_ptr;
    logic [AW:0] ptr_nxt;
    logic        go;
    logic        full;
    logic        ovf_evt;

    osf_sync2 #(.W(AW + 1)) u_sync_rptr (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rd_gray_x),
        .q     (rd_gray_s)
    );

    osf_sync2 #(.W(1)) u_sync_flush (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flush_tgl_x),
        .q     (flush_s)
    );

    // Decode the write enable, full state and overflow event.
    always_comb begin
        flush_evt = flush_s ^ flush_prev;
        go        = active || mark;
        full      = (wr_gray == {~rd_gray_s[AW:AW-1], rd_gray_s[AW-2:0]});
        wr_en     = go && !full && !flush_evt;
        ovf_evt   = go && full && !flush_evt;
        ptr_nxt   = wr_ptr + (AW + 1)'(1);
        wr_addr   = wr_ptr[AW-1:0];
    end

    // Pointer, arming state and event toggles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_prev <= 1'b0;
            active     <= 1'b0;
            wr_ptr     <= '0;
            wr_gray    <= '0;
            ovf_tgl    <= 1'b0;
        end else begin
            flush_prev <= flush_s;
            if (flush_evt) begin
                active  <= 1'b0;
                wr_ptr  <= '0;
                wr_gray <= '0;
            end else begin
                if (mark) begin
                    active <= 1'b1;
                end
                if (wr_en) begin
                    wr_ptr  <= ptr_nxt;
                    wr_gray <= ptr_nxt ^ (ptr_nxt >> 1);
                end
                if (ovf_evt) begin
                    ovf_tgl <= ~ovf_tgl;
                end
            end
        end
    end
endmodule

// File: rtl/osf_rd_ctrl.sv
// Read-side control: release by the shared receive marker, Gray read
// pointer, empty detection, registered output, channel gating, flush
// toggle toward the write side and the sticky error bit.
module osf_rd_ctrl
    import osf_pkg::*;
#(
    parameter int unsigned AW = 7,
    parameter int unsigned DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          orbit,
    input  logic          flush,
    input  logic          chan_en,
    input  logic          err_clr,
    input  logic [AW:0]   wr_gray_x,
    input  logic          ovf_tgl_x,
    input  logic [DW-1:0] mem_q,
    output logic [AW-1:0] rd_addr,
    output logic [AW:0]   rd_gray,
    output logic          flush_tgl,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          sync_err
);
    rd_state_e   state;
    logic [AW:0] wr_gray_s;
    logic        ovf_s;
    logic        ovf_prev;
    logic [AW:0] rd_ptr;
    logic [AW:0] ptr_nxt;
    logic        empty;
    logic        do_read;
    logic        udf;
    logic        set_err;

    osf_sync2 #(.W(AW + 1)) u_sync_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (wr_gray_x),
        .q     (wr_gray_s)
    );

    osf_sync2 #(.W(1)) u_sync_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ovf_tgl_x),
        .q     (ovf_s)
    );

    // Decode read, underflow and error-set conditions.
    always_comb begin
        empty   = (rd_gray == wr_gray_s);
        do_read = (state == RD_RUN) && chan_en && !empty;
        udf     = (state == RD_RUN) && chan_en && empty;
        set_err = chan_en && (udf || (ovf_s ^ ovf_prev));
        ptr_nxt = rd_ptr + (AW + 1)'(1);
        rd_addr = rd_ptr[AW-1:0];
    end

    // Read state: a flush stops reading, the receive marker releases it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_IDLE;
        end else if (flush) begin
            state <= RD_IDLE;
        end else if (orbit) begin
            state <= RD_RUN;
        end
    end

    // Read pointer and the flush toggle sent to the write side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr    <= '0;
            rd_gray   <= '0;
            flush_tgl <= 1'b0;
        end else if (flush) begin
            rd_ptr    <= '0;
            rd_gray   <= '0;
            flush_tgl <= ~flush_tgl;
        end else if (do_read) begin
            rd_ptr  <= ptr_nxt;
            rd_gray <= ptr_nxt ^ (ptr_nxt >> 1);
        end
    end

    // Registered output, zero whenever no word is delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_data  <= do_read ? mem_q : '0;
            rd_valid <= do_read;
        end
    end

    // Sticky error bit with the overflow edge detector; set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_prev <= 1'b0;
            sync_err <= 1'b0;
        end else begin
            ovf_prev <= ovf_s;
            if (set_err) begin
                sync_err <= 1'b1;
            end else if (err_clr) begin
                sync_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/orbit_sync_fifo.sv
// Top level: one channel of orbit-aligned dual-clock synchronization.
// Assumes flush, chan_en, err_clr and rd_orbit are in the read domain,
// and wr_orbit and cfg_delay in the write domain.
module orbit_sync_fifo
    import osf_pkg::*;
#(
    parameter int unsigned DATA_W = OSF_DATA_W,
    parameter int unsigned DEPTH  = OSF_DEPTH,
    parameter int unsigned DLY_W  = OSF_DLY_W
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_orbit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DLY_W-1:0]  cfg_delay,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_orbit,
    input  logic              flush,
    input  logic              chan_en,
    input  logic              err_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              sync_err
);
    localparam int unsigned AW = $clog2(DEPTH);

    logic              mark_w;
    logic              wr_en_w;
    logic [AW-1:0]     wr_addr_w;
    logic [AW:0]       wr_gray_w;
    logic              ovf_tgl_w;
    logic              wr_flush_evt;
    logic [AW-1:0]     rd_addr_w;
    logic [AW:0]       rd_gray_w;
    logic              flush_tgl_w;
    logic [DATA_W-1:0] mem_q_w;

    osf_orbit_delay #(.DLY_W(DLY_W)) u_delay (
        .clk      (wr_clk),
        .rst_n    (wr_rst_n),
        .orbit_in (wr_orbit),
        .delay    (cfg_delay),
        .mark_out (mark_w)
    );

    osf_wr_ctrl #(.AW(AW)) u_wr (
        .clk         (wr_clk),
        .rst_n       (wr_rst_n),
        .mark        (mark_w),
        .rd_gray_x   (rd_gray_w),
        .flush_tgl_x (flush_tgl_w),
        .wr_en       (wr_en_w),
        .wr_addr     (wr_addr_w),
        .wr_gray     (wr_gray_w),
        .ovf_tgl     (ovf_tgl_w),
        .flush_evt   (wr_flush_evt)
    );

    osf_dpram #(.DW(DATA_W), .AW(AW)) u_mem (
        .wr_clk (wr_clk),
        .we     (wr_en_w),
        .waddr  (wr_addr_w),
        .wdata  (wr_data),
        .raddr  (rd_addr_w),
        .rdata  (mem_q_w)
    );

    osf_rd_ctrl #(.AW(AW), .DW(DATA_W)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .orbit     (rd_orbit),
        .flush     (flush),
        .chan_en   (chan_en),
        .err_clr   (err_clr),
        .wr_gray_x (wr_gray_w),
        .ovf_tgl_x (ovf_tgl_w),
        .mem_q     (mem_q_w),
        .rd_addr   (rd_addr_w),
        .rd_gray   (rd_gray_w),
        .flush_tgl (flush_tgl_w),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .sync_err  (sync_err)
    );
endmodule

// File: rtl/osf_checker.sv
// Property checker for orbit_sync_fifo, attached by bind below.
module osf_checker #(
    parameter int unsigned AW = 7,
    parameter int unsigned DW = 9
) (
    input logic          wr_clk,
    input logic          wr_rst_n,
    input logic          rd_clk,
    input logic          rd_rst_n,
    input logic [AW:0]   wr_gray,
    input logic          wr_flush_evt,
    input logic [AW:0]   rd_gray,
    input logic          flush,
    input logic          chan_en,
    input logic          err_clr,
    input logic [DW-1:0] rd_data,
    input logic          rd_valid,
    input logic          sync_err
);
    // R3: the write pointer crosses domains changing one bit at a time.
    assert_wr_gray_step_R3: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !wr_flush_evt |=> $onehot0(wr_gray ^ $past(wr_gray)));

    // R3: the read pointer crosses domains changing one bit at a time.
    assert_rd_gray_step_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !flush |=> $onehot0(rd_gray ^ $past(rd_gray)));

    // R4: two receive cycles after a flush no word is delivered.
    assert_flush_idle_R4: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        flush |-> ##2 !rd_valid);

    // R8: the error bit holds until cleared.
    assert_err_sticky_R8: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (sync_err && !err_clr) |=> sync_err);

    // R9: a disabled channel never raises the error bit.
    assert_disabled_no_err_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!chan_en && !sync_err) |=> !sync_err);

    // R9: a disabled channel delivers nothing and drives zero.
    assert_disabled_quiet_R9: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        !chan_en |=> (!rd_valid && (rd_data == '0)));
endmodule

bind orbit_sync_fifo osf_checker #(.AW(AW), .DW(DATA_W)) u_chk (
    .wr_clk       (wr_clk),
    .wr_rst_n     (wr_rst_n),
    .rd_clk       (rd_clk),
    .rd_rst_n     (rd_rst_n),
    .wr_gray      (wr_gray_w),
    .wr_flush_evt (wr_flush_evt),
    .rd_gray      (rd_gray_w),
    .flush        (flush),
    .chan_en      (chan_en),
    .err_clr      (err_clr),
    .rd_data      (rd_data),
    .rd_valid     (rd_valid),
    .sync_err     (sync_err)
);

// File: tb/orbit_sync_fifo_tb.sv
// Self-checking bench: vector table of delay/base pairs, then directed tests.
module orbit_sync_fifo_tb;
    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0;
    logic       rd_rst_n = 1'b0;
    logic       wr_orbit = 1'b0;
    logic [8:0] wr_data = '0;
    logic [11:0] cfg_delay = '0;
    logic       rd_orbit = 1'b0;
    logic       flush = 1'b0;
    logic       chan_en = 1'b1;
    logic       err_clr = 1'b0;
    logic [8:0] rd_data;
    logic       rd_valid;
    logic       sync_err;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Each entry: {delay[20:9], base word[8:0]}
    localparam logic [20:0] VEC [0:4] = '{
        {12'd0,   9'h010},
        {12'd1,   9'h100},
        {12'd5,   9'h1FD},
        {12'd37,  9'h055},
        {12'd200, 9'h000}
    };

    orbit_sync_fifo u_dut (
        .wr_clk    (wr_clk),
        .wr_rst_n  (wr_rst_n),
        .wr_orbit  (wr_orbit),
        .wr_data   (wr_data),
        .cfg_delay (cfg_delay),
        .rd_clk    (rd_clk),
        .rd_rst_n  (rd_rst_n),
        .rd_orbit  (rd_orbit),
        .flush     (flush),
        .chan_en   (chan_en),
        .err_clr   (err_clr),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .sync_err  (sync_err)
    );

    // 250 MHz receive clock; write clock at the same rate, phase shifted.
    always #2 rd_clk = ~rd_clk;
    initial begin
        #0.7;
        forever #2 wr_clk = ~wr_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic rd_wait(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic do_flush();
        @(negedge rd_clk) flush = 1'b1;
        @(negedge rd_clk) flush = 1'b0;
        rd_wait(30);
    endtask

    task automatic clear_err();
        @(negedge rd_clk) err_clr = 1'b1;
        @(negedge rd_clk) err_clr = 1'b0;
        rd_wait(2);
    endtask

    // Word base+j is presented in write cycle j; the orbit pulse is in cycle 0.
    task automatic run_write(input int d, input logic [8:0] base, input int n);
        cfg_delay = 12'(d);
        @(negedge wr_clk);
        for (int j = 0; j < d + n; j++) begin
            wr_orbit = (j == 0);
            wr_data  = base + 9'(j);
            @(negedge wr_clk);
        end
        wr_orbit = 1'b0;
    endtask

    // Release reading and compare n delivered words against a counting sequence.
    task automatic read_check(input logic [8:0] first, input int n, input string req);
        int got = 0;
        int bad = 0;
        int bad_act = 0;
        int bad_exp = 0;
        @(negedge rd_clk) rd_orbit = 1'b1;
        @(negedge rd_clk) rd_orbit = 1'b0;
        for (int k = 0; k < n + 40 && got < n; k++) begin
            if (rd_valid) begin
                if (rd_data != 9'(first + 9'(got))) begin
                    if (bad == 0) begin
                        bad_act = int'(rd_data);
                        bad_exp = int'(9'(first + 9'(got)));
                    end
                    bad++;
                end
                got++;
            end
            @(negedge rd_clk);
        end
        chk(got == n, req, got, n);
        chk(bad == 0, req, bad_act, bad_exp);
    endtask

    initial begin
        logic [8:0] b;
        int d;
        int seen;
        rd_wait(2);
        // R1: outputs quiet during reset
        chk(rd_valid == 1'b0 && rd_data == '0 && sync_err == 1'b0, "R1", int'(rd_data), 0);
        rd_wait(8);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        rd_wait(3);
        chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
        chk(rd_data == '0, "R1", int'(rd_data), 0);
        chk(sync_err == 1'b0, "R1", int'(sync_err), 0);

        // R2/R3/R4: vector table of delays and base words
        for (int i = 0; i < 5; i++) begin
            d = int'(VEC[i][20:9]);
            b = VEC[i][8:0];
            do_flush();
            run_write(d, b, 41);
            seen = 0;
            for (int k = 0; k < 5; k++) begin
                if (rd_valid) seen++;
                @(negedge rd_clk);
            end
            chk(seen == 0, "R4", seen, 0);
            read_check(9'(b + 9'(d)), 8, "R2");
            chk(sync_err == 1'b0, "R3", int'(sync_err), 0);
        end

        // R5: flush discards old words; new marker realigns
        do_flush();
        run_write(0, 9'h0A0, 30);
        do_flush();
        run_write(2, 9'h150, 10);
        read_check(9'h152, 6, "R5");

        // R6: 128-word depth, overflow drops new words and flags
        do_flush();
        clear_err();
        chk(sync_err == 1'b0, "R8", int'(sync_err), 0);
        run_write(0, 9'h000, 150);
        rd_wait(10);
        chk(sync_err == 1'b1, "R6", int'(sync_err), 1);
        read_check(9'h000, 128, "R6");
        seen = -1;
        for (int k = 0; k < 20 && seen < 0; k++) begin
            if (rd_valid) seen = int'(rd_data);
            @(negedge rd_clk);
        end
        chk(seen == 149, "R6", seen, 149);
        do_flush();
        chk(sync_err == 1'b1, "R8", int'(sync_err), 1);
        clear_err();
        chk(sync_err == 1'b0, "R8", int'(sync_err), 0);

        // R7: released reading with nothing stored
        @(negedge rd_clk) rd_orbit = 1'b1;
        @(negedge rd_clk) rd_orbit = 1'b0;
        rd_wait(10);
        chk(sync_err == 1'b1, "R7", int'(sync_err), 1);
        chk(rd_valid == 1'b0, "R7", int'(rd_valid), 0);
        do_flush();
        chk(sync_err == 1'b1, "R8", int'(sync_err), 1);
        clear_err();
        chk(sync_err == 1'b0, "R8", int'(sync_err), 0);

        // R9: disabled channel stays silent with data stored and reading released
        chan_en = 1'b0;
        do_flush();
        run_write(3, 9'h033, 20);
        @(negedge rd_clk) rd_orbit = 1'b1;
        @(negedge rd_clk) rd_orbit = 1'b0;
        seen = 0;
        for (int k = 0; k < 20; k++) begin
            if (rd_valid || rd_data != '0) seen++;
            @(negedge rd_clk);
        end
        chk(seen == 0, "R9", seen, 0);
        do_flush();
        @(negedge rd_clk) rd_orbit = 1'b1;
        @(negedge rd_clk) rd_orbit = 1'b0;
        rd_wait(10);
        chk(sync_err == 1'b0, "R9", int'(sync_err), 0);
        do_flush();
        chan_en = 1'b1;
        rd_wait(5);
        chk(sync_err == 1'b0, "R9", int'(sync_err), 0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(100000 * 4);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule